// File: doc/BRIEF.md
# Multithreaded Issue Thread Scheduler

This block decides, every clock cycle, which hardware thread of a single-issue, in-order, multithreaded pipeline gets the one issue slot. Memory operations in that pipeline have a long, fixed latency, and the load/store path is non-blocking. A thread may therefore keep issuing independent work while its loads are still in flight. Instruction fetch, the datapath and the memory system are outside the block. They report, for every thread, the register IDs that its next instruction reads and writes, and they announce each load as it is issued and as it returns.

Each thread has a scoreboard with one pending bit per architectural register. A thread is ready when none of the registers named by its next instruction is pending. A returning load is bypassed, so its register counts as ready in the same cycle. Register 0 is hardwired to zero and is never marked pending.

Two policies are available:

- **Fixed round-robin.** The slot moves to the next thread every cycle. A blocked thread wastes its own slot.
- **Switch-on-stall.** The current thread keeps the slot until it blocks. Selection then moves, at no cycle cost, to the first ready thread found by scanning upward with wrap-around.

A three-state controller holds the policy:

- **RR_STEP** is the round-robin policy.
- **SOS_HOLD** is switch-on-stall after a cycle in which some thread was ready.
- **SOS_SEEK** is switch-on-stall after a cycle in which no thread was ready.

The controller moves on every clock edge:

- A low mode select leads from any state to RR_STEP.
- A high mode select leads to SOS_HOLD when the scan finds a ready thread in that cycle.
- A high mode select leads to SOS_SEEK when the scan finds no ready thread in that cycle.

The mode select is sampled at the clock edge, so a change of policy applies from the following cycle.

Top module: `mts_sched`

## Requirements
- R1: A synchronous active-high reset clears every pending bit of every thread, selects thread 0 and enters RR_STEP. In the first cycle after reset, issue_tid is 0 and issue_valid is 1 whatever registers the threads name.
- R2: In RR_STEP, issue_tid steps through 0, 1, … NUM_THREADS-1 and wraps to 0, advancing by one every cycle whether or not the selected thread issues.
- R3: In RR_STEP, when the thread in the slot is blocked, issue_valid is 0 and issue_tid still shows that thread. The slot is not given to another thread, and the next cycle moves on to the following thread.
- R4: A thread is blocked when its src_a, src_b or dst field (thread t at bits [t*REG_W +: REG_W] of each flat bus) names a register that is pending in that thread's own scoreboard. The same register ID pending in another thread has no effect.
- R5: A load issue event (ld_issue with ld_issue_tid and ld_issue_rd) marks that register pending from the next cycle on. A load issue to register 0 has no effect.
- R6: A load return event (ld_ret with ld_ret_tid and ld_ret_rd) clears the pending bit and counts as ready in the same cycle. When an issue and a return name the same thread and register in one cycle, the register stays pending.
- R7: In SOS_HOLD or SOS_SEEK, while the current thread is ready, it issues every cycle and stays selected.
- R8: In SOS_HOLD or SOS_SEEK, when the current thread is blocked, the same cycle issues from the first ready thread found by scanning cur+1, cur+2, … with wrap-around. That thread becomes the current thread.
- R9: In SOS_HOLD or SOS_SEEK, when no thread is ready, issue_valid is 0, issue_tid shows the current thread, and the current thread is unchanged in the next cycle.
- R10: mode_sel (0 = round-robin, 1 = switch-on-stall) is sampled at the clock edge. The policy of a cycle is the one selected in the previous cycle, and the current thread carries over across a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 = round-robin, 1 = switch-on-stall |
| nxt_src_a | input | NUM_THREADS*REG_W | First source register of each thread's next instruction |
| nxt_src_b | input | NUM_THREADS*REG_W | Second source register of each thread's next instruction |
| nxt_dst | input | NUM_THREADS*REG_W | Destination register of each thread's next instruction |
| ld_issue | input | 1 | A load is issued this cycle |
| ld_issue_tid | input | TID_W | Thread of the issued load |
| ld_issue_rd | input | REG_W | Destination register of the issued load |
| ld_ret | input | 1 | A load returns this cycle |
| ld_ret_tid | input | TID_W | Thread of the returning load |
| ld_ret_rd | input | REG_W | Destination register of the returning load |
| issue_tid | output | TID_W | Thread selected this cycle |
| issue_valid | output | 1 | The selected thread issues this cycle |

## Verification
A pending bit that is stuck or lost shows up the next time that thread comes into view. In round-robin mode that is at most NUM_THREADS cycles later, as issue_valid wrongly high or low in its slot. A wrong current thread or controller state shows up on issue_tid in the very next cycle. Round-robin gives a fixed, predictable sequence, while switch-on-stall either holds the thread or jumps to a specific one. The vectors therefore mix cycles in which blocked and ready threads sit on both sides of the current thread. They also line up load issues and returns on the same register, so that set, clear and bypass faults each change a specific issue_valid bit.

// File: rtl/mts_pkg.sv
package mts_pkg;

    // Scheduling policy states
    typedef enum logic [1:0] {
        ST_RR_STEP  = 2'd0,
        ST_SOS_HOLD = 2'd1,
        ST_SOS_SEEK = 2'd2
    } sched_state_e;

endpackage

// File: rtl/mts_scoreboard.sv
module mts_scoreboard #(
    parameter int NUM_REGS = 32,
    localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_rd,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_rd,
    input  logic [REG_W-1:0] chk_a,
    input  logic [REG_W-1:0] chk_b,
    input  logic [REG_W-1:0] chk_d,
    output logic             ready
);

    logic [NUM_REGS-1:0] pend;
    logic [NUM_REGS-1:0] set_vec;
    logic [NUM_REGS-1:0] clr_vec;
    logic [NUM_REGS-1:0] pend_eff;

    // Register 0 is hardwired zero and never becomes pending
    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        if (set_en && (set_rd != '0)) begin
            set_vec[set_rd] = 1'b1;
        end
        if (clr_en) begin
            clr_vec[clr_rd] = 1'b1;
        end
    end

    // New issue wins over a return to the same register
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_vec) | set_vec;
        end
    end

    // Bypass: a register returning now already counts as ready
    always_comb begin
        pend_eff = pend & ~clr_vec;
        ready = !(pend_eff[chk_a] || pend_eff[chk_b] || pend_eff[chk_d]);
    end

    // R5: an issued load marks its register pending in the next cycle
    a_r5_set_visible: assert property (@(posedge clk) disable iff (rst)
        (set_en && (set_rd != '0)) |=> pend[$past(set_rd)]);

    // R6: a return without a competing issue clears the bit
    a_r6_clear_visible: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && (set_rd == clr_rd))) |=> !pend[$past(clr_rd)]);

endmodule

// File: rtl/mts_pick.sv
module mts_pick #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic [NUM_THREADS-1:0] ready,
    input  logic [TID_W-1:0]       base,
    output logic                   found,
    output logic [TID_W-1:0]       pick
);

    logic [TID_W:0] idx;

    // Scan base, base+1, ... with wrap-around; the lowest offset wins
    always_comb begin
        found = 1'b0;
        pick  = base;
        idx   = '0;
        for (int k = NUM_THREADS - 1; k >= 0; k--) begin
            idx = {1'b0, base} + (TID_W + 1)'(k);
            if (idx >= (TID_W + 1)'(NUM_THREADS)) begin
                idx = idx - (TID_W + 1)'(NUM_THREADS);
            end
            if (ready[idx[TID_W-1:0]]) begin
                found = 1'b1;
                pick  = idx[TID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mts_sched.sv
module mts_sched
    import mts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_REGS = 32,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int REG_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_sel,
    input  logic [NUM_THREADS*REG_W-1:0] nxt_src_a,
    input  logic [NUM_THREADS*REG_W-1:0] nxt_src_b,
    input  logic [NUM_THREADS*REG_W-1:0] nxt_dst,
    input  logic                         ld_issue,
    input  logic [TID_W-1:0]             ld_issue_tid,
    input  logic [REG_W-1:0]             ld_issue_rd,
    input  logic                         ld_ret,
    input  logic [TID_W-1:0]             ld_ret_tid,
    input  logic [REG_W-1:0]             ld_ret_rd,
    output logic [TID_W-1:0]             issue_tid,
    output logic                         issue_valid
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    sched_state_e          state;
    sched_state_e          state_nxt;
    logic [TID_W-1:0]      cur_tid;
    logic [TID_W-1:0]      cur_nxt;
    logic [NUM_THREADS-1:0] thr_ready;
    logic                  scan_found;
    logic [TID_W-1:0]      scan_pick;

    // One scoreboard per thread
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        mts_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
            .clk    (clk),
            .rst    (rst),
            .set_en (ld_issue && (ld_issue_tid == TID_W'(t))),
            .set_rd (ld_issue_rd),
            .clr_en (ld_ret && (ld_ret_tid == TID_W'(t))),
            .clr_rd (ld_ret_rd),
            .chk_a  (nxt_src_a[t*REG_W +: REG_W]),
            .chk_b  (nxt_src_b[t*REG_W +: REG_W]),
            .chk_d  (nxt_dst[t*REG_W +: REG_W]),
            .ready  (thr_ready[t])
        );
    end

    mts_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
        .ready (thr_ready),
        .base  (cur_tid),
        .found (scan_found),
        .pick  (scan_pick)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RR_STEP;
            cur_tid <= '0;
        end else begin
            state   <= state_nxt;
            cur_tid <= cur_nxt;
        end
    end

    // Next policy state
    always_comb begin
        if (!mode_sel) begin
            state_nxt = ST_RR_STEP;
        end else if (scan_found) begin
            state_nxt = ST_SOS_HOLD;
        end else begin
            state_nxt = ST_SOS_SEEK;
        end
    end

    // Outputs and next current thread
    always_comb begin
        issue_tid   = cur_tid;
        issue_valid = 1'b0;
        cur_nxt     = cur_tid;
        unique case (state)
            ST_RR_STEP: begin
                issue_tid   = cur_tid;
                issue_valid = thr_ready[cur_tid];
                cur_nxt     = (cur_tid == LAST_TID) ? '0 : cur_tid + 1'b1;
            end
            ST_SOS_HOLD, ST_SOS_SEEK: begin
                issue_tid   = scan_found ? scan_pick : cur_tid;
                issue_valid = scan_found;
                cur_nxt     = scan_found ? scan_pick : cur_tid;
            end
            default: begin
                issue_tid   = cur_tid;
                issue_valid = 1'b0;
                cur_nxt     = cur_tid;
            end
        endcase
    end

    // R2: round-robin advances by one, wrapping after the last thread
    a_r2_rr_advance: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RR_STEP && !mode_sel) |=>
        (issue_tid == (($past(issue_tid) == LAST_TID) ? '0 : $past(issue_tid) + 1'b1)));

    // R8: an issued thread is always ready in its own scoreboard
    a_r8_valid_is_ready: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> thr_ready[issue_tid]);

    // R7: in switch-on-stall the issuing thread becomes the current one
    a_r7_sos_keeps_issuer: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RR_STEP && mode_sel && issue_valid) |=> (cur_tid == $past(issue_tid)));

    // R9: nothing ready leaves the current thread in place
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RR_STEP && mode_sel && !issue_valid) |=> $stable(cur_tid));

    // R10: mode low selects round-robin from the next cycle
    a_r10_mode_follow: assert property (@(posedge clk) disable iff (rst)
        !mode_sel |=> (state == ST_RR_STEP));

endmodule

// File: tb/mts_sched_test.sv
module mts_sched_test;

    localparam int NT = 4;
    localparam int RW = 5;
    localparam int NV = 22;

    // Vector layout: mode, ld(v,tid,rd), ret(v,tid,rd), src_a t3..t0, exp valid, exp tid
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd0,5'd0,5'd0, 1'b1,2'd0}, // R1 first slot
        {1'b0, 1'b1,2'd2,5'd5, 1'b0,2'd0,5'd0, 5'd0,5'd0,5'd0,5'd0, 1'b1,2'd1}, // R2 step
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd0,5'd0, 1'b0,2'd2}, // R3 blocked slot
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd0,5'd0, 1'b1,2'd3}, // R3 no reassign
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd0,5'd0, 1'b1,2'd0}, // R2 wrap
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd5,5'd0, 1'b1,2'd1}, // R4 per thread
        {1'b0, 1'b0,2'd0,5'd0, 1'b1,2'd2,5'd5, 5'd0,5'd5,5'd0,5'd0, 1'b1,2'd2}, // R6 bypass
        {1'b0, 1'b1,2'd0,5'd7, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd0,5'd0, 1'b1,2'd3}, // R2
        {1'b1, 1'b1,2'd1,5'd9, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd0,5'd7, 1'b0,2'd0}, // R10 still RR
        {1'b1, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd9,5'd7, 1'b1,2'd2}, // R8 switch
        {1'b1, 1'b1,2'd2,5'd4, 1'b0,2'd0,5'd0, 5'd0,5'd5,5'd9,5'd7, 1'b1,2'd2}, // R7 hold
        {1'b1, 1'b1,2'd3,5'd6, 1'b0,2'd0,5'd0, 5'd0,5'd4,5'd9,5'd7, 1'b1,2'd3}, // R8 switch
        {1'b1, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b0,2'd3}, // R9 none ready
        {1'b1, 1'b0,2'd0,5'd0, 1'b1,2'd1,5'd9, 5'd6,5'd4,5'd9,5'd7, 1'b1,2'd1}, // R8 wrap scan
        {1'b1, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b1,2'd1}, // R7 hold
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b1,2'd1}, // R10 still SoS
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b1,2'd1}, // R10 RR from cur
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b0,2'd2}, // R3
        {1'b0, 1'b1,2'd0,5'd7, 1'b1,2'd0,5'd7, 5'd6,5'd4,5'd9,5'd7, 1'b0,2'd3}, // R3
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd6,5'd4,5'd9,5'd7, 1'b0,2'd0}, // R6 issue wins
        {1'b0, 1'b1,2'd2,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd0,5'd0,5'd0, 1'b1,2'd1}, // R2
        {1'b0, 1'b0,2'd0,5'd0, 1'b0,2'd0,5'd0, 5'd0,5'd0,5'd0,5'd0, 1'b1,2'd2}  // R5 reg 0
    };
    localparam int VTAG [NV] = '{1,2,3,3,2,4,6,2,10,8,7,8,9,8,7,10,10,3,3,6,2,5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic [RW-1:0] sa [NT];
    logic [RW-1:0] sb [NT];
    logic [RW-1:0] dd [NT];
    logic [NT*RW-1:0] src_a_bus, src_b_bus, dst_bus;
    logic ld_issue = 1'b0, ld_ret = 1'b0;
    logic [1:0] ld_issue_tid = '0, ld_ret_tid = '0;
    logic [RW-1:0] ld_issue_rd = '0, ld_ret_rd = '0;
    logic [1:0] issue_tid;
    logic issue_valid;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            src_a_bus[t*RW +: RW] = sa[t];
            src_b_bus[t*RW +: RW] = sb[t];
            dst_bus[t*RW +: RW]   = dd[t];
        end
    end

    mts_sched #(.NUM_THREADS(NT), .NUM_REGS(32)) uut (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .nxt_src_a    (src_a_bus),
        .nxt_src_b    (src_b_bus),
        .nxt_dst      (dst_bus),
        .ld_issue     (ld_issue),
        .ld_issue_tid (ld_issue_tid),
        .ld_issue_rd  (ld_issue_rd),
        .ld_ret       (ld_ret),
        .ld_ret_tid   (ld_ret_tid),
        .ld_ret_rd    (ld_ret_rd),
        .issue_tid    (issue_tid),
        .issue_valid  (issue_valid)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Sample mid low phase, then move to the next falling edge
    task automatic check(input logic ev, input logic [1:0] et, input int tag);
        #5;
        n_chk++;
        if (issue_valid !== ev || issue_tid !== et) begin
            n_fail++;
            $display("FAIL R%0d: valid/tid got %0b/%0d expected %0b/%0d",
                     tag, issue_valid, issue_tid, ev, et);
        end
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        for (int t = 0; t < NT; t++) begin
            sa[t] = '0;
            sb[t] = '0;
            dd[t] = '0;
        end
        ld_issue = 1'b0;
        ld_ret   = 1'b0;
        mode_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            mode_sel     = VEC[v][39];
            ld_issue     = VEC[v][38];
            ld_issue_tid = VEC[v][37:36];
            ld_issue_rd  = VEC[v][35:31];
            ld_ret       = VEC[v][30];
            ld_ret_tid   = VEC[v][29:28];
            ld_ret_rd    = VEC[v][27:23];
            sa[3]        = VEC[v][22:18];
            sa[2]        = VEC[v][17:13];
            sa[1]        = VEC[v][12:8];
            sa[0]        = VEC[v][7:3];
            check(VEC[v][2], VEC[v][1:0], VTAG[v]);
        end

        // R1: reset clears scoreboards that held pending loads
        clear_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        sa[0] = 5'd7;
        sa[2] = 5'd4;
        sa[3] = 5'd6;
        check(1'b1, 2'd0, 1);
        check(1'b1, 2'd1, 1);
        check(1'b1, 2'd2, 1);
        check(1'b1, 2'd3, 1);

        // R4: destination and second source hazards
        ld_issue = 1'b1; ld_issue_tid = 2'd1; ld_issue_rd = 5'd12;
        dd[1] = 5'd12;
        check(1'b1, 2'd0, 4);
        ld_issue = 1'b0;
        check(1'b0, 2'd1, 4);
        sb[2] = 5'd12;
        ld_issue = 1'b1; ld_issue_tid = 2'd2; ld_issue_rd = 5'd13;
        check(1'b1, 2'd2, 4);
        ld_issue = 1'b0;
        sb[2] = 5'd13;
        check(1'b1, 2'd3, 4);
        check(1'b1, 2'd0, 4);
        check(1'b0, 2'd1, 4);
        check(1'b0, 2'd2, 4);

        summary();
        $finish;
    end

endmodule